// File: doc/BRIEF.md
# Spectral Test Pattern Generator with Reseeding

This block is an on-chip pattern source for self-test of a small circuit under test (eight inputs by default). Every output bit is built from one chosen Walsh waveform, taken from a row of the Hadamard matrix in natural order, and then perturbed by a sparse random bit. The Walsh waveform comes from a 3-bit time counter. Row `k` at time `t` is a 1 when `k AND t` has even parity and a 0 when the parity is odd, so row 0 is all ones. The random bit is the AND of two taps of a 16-bit LFSR, which makes it a 1 about a quarter of the time. A 1 in the random bit flips the Walsh bit.

The generator state (time counter and LFSR) is the seed. A tester can load it in one cycle over a parallel word, or shift it in one bit per cycle over a serial line. There are two operating modes. In seed-per-vector mode the state never moves on its own, so every load yields exactly one vector. In hybrid mode the generator steps freely, and it raises a request once a programmed number of vectors has been produced since the last reseed. When a sequential circuit needs each vector held for several clocks, a hold input spaces the steps by a programmable divide ratio.

Top module: `spectral_tpg`

## Requirements
- R1: After reset the time counter is 0, the LFSR holds `RST_LFSR` (16'hACE1), `vec_strobe` is 0 and `seed_request` is 0.
- R2: `vec_out[i]` equals the Walsh bit of row `row_sel[3i+2:3i]` at the current time `t`, XOR the noise bit of input i. The Walsh bit is 1 when the parity of (row AND t) is even.
- R3: The noise bit of input i is `lfsr[i] AND lfsr[i+8]`.
- R4: With `par_load` high, the whole seed is loaded at that edge: t = `par_seed[18:16]`, lfsr = `par_seed[15:0]`. `vec_strobe` is high in the following cycle. `par_load` takes priority over `ser_load`.
- R5: Each edge with `ser_load` high (and `par_load` low) shifts the 19-bit seed {t, lfsr} left by one, with `ser_bit` entering bit 0. A word is therefore sent MSB first in 19 cycles. `vec_strobe` is high in the cycle after the one in which `ser_load` drops.
- R6: With `mode_hybrid` = 0 the seed changes only through loads.
- R7: In hybrid mode each step sets t to t+1 mod 8 and shifts the LFSR left, with bit 15^13^12^10 entering bit 0. `vec_strobe` is high in the cycle after each step.
- R8: In hybrid mode with `hold_en` = 0 a step happens at every edge. With `hold_en` = 1 a step happens every `max(div_ratio,1)` edges, and the first step comes `max(div_ratio,1)` edges after the last load edge.
- R9: No step happens at an edge where either load is high, and a load restarts the step spacing.
- R10: `seed_request` = `mode_hybrid` AND (steps since the last load ≥ `reseed_budget`). The step count saturates and any load clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_hybrid | input | 1 | 0: one seed per vector, 1: free-running with occasional reseeds |
| hold_en | input | 1 | Spaces steps by the divide ratio |
| div_ratio | input | 8 | Edges per vector when holding (0 treated as 1) |
| reseed_budget | input | 16 | Steps allowed before a reseed is requested |
| row_sel | input | 24 | 3-bit Walsh row index per output, input i at bits 3i+2:3i |
| par_load | input | 1 | Parallel seed load |
| par_seed | input | 19 | Parallel seed {t[2:0], lfsr[15:0]} |
| ser_load | input | 1 | Serial seed shift enable |
| ser_bit | input | 1 | Serial seed data, MSB first |
| vec_out | output | 8 | Pattern to the circuit under test |
| vec_strobe | output | 1 | New vector presented this cycle |
| seed_request | output | 1 | Hybrid mode wants a new seed |

## Verification
`vec_out` is a combinational function of the registered seed. A load or step at edge n therefore shows on `vec_out` and `vec_strobe` right after edge n, and the bench samples 1 ns after that edge, before it drives the next inputs. The serial strobe is registered once more, so it is checked one edge after `ser_load` drops. With hold enabled, the step is expected at edge k·D after the load edge, and every edge in between is checked for an unchanged vector and a low strobe. `seed_request` depends combinationally on the registered step count, so it is checked right after the edge that brings the count up to the budget.

// File: rtl/spectral_tpg_pkg.sv
package spectral_tpg_pkg;
    localparam int LFSR_W = 16;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/tpg_pace.sv
module tpg_pace #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold_en,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q, last;

    always_comb begin
        last  = (!hold_en || div_ratio == '0) ? '0 : div_ratio - DIV_W'(1);
        tick  = run && (cnt_q >= last);
        cnt_d = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: with a ratio above one, steps never fall on adjacent edges
    p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || !hold_en || div_ratio <= DIV_W'(1)));
endmodule

// File: rtl/tpg_synth.sv
module tpg_synth #(
    parameter int N_IN   = 8,
    parameter int T_W    = 3,
    parameter int LFSR_W = 16
) (
    input  logic [T_W-1:0]      t,
    input  logic [LFSR_W-1:0]   lfsr,
    input  logic [N_IN*T_W-1:0] row_sel,
    output logic [N_IN-1:0]     vec
);
    logic [N_IN-1:0] walsh, noise;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign walsh[i] = ~^(row_sel[i*T_W +: T_W] & t);
        assign noise[i] = lfsr[i] & lfsr[i+N_IN];
        assign vec[i]   = walsh[i] ^ noise[i];
    end
endmodule

// File: rtl/spectral_tpg.sv
module spectral_tpg
    import spectral_tpg_pkg::*;
#(
    parameter int              N_IN     = 8,
    parameter int              T_W      = 3,
    parameter int              CNT_W    = 16,
    parameter int              DIV_W    = 8,
    parameter logic [15:0]     RST_LFSR = 16'hACE1,
    localparam int             SEED_W   = T_W + LFSR_W,
    localparam int             ROW_W    = N_IN * T_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_hybrid,
    input  logic              hold_en,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic [CNT_W-1:0]  reseed_budget,
    input  logic [ROW_W-1:0]  row_sel,
    input  logic              par_load,
    input  logic [SEED_W-1:0] par_seed,
    input  logic              ser_load,
    input  logic              ser_bit,
    output logic [N_IN-1:0]   vec_out,
    output logic              vec_strobe,
    output logic              seed_request
);
    typedef struct packed {
        logic [T_W-1:0]    t;
        logic [LFSR_W-1:0] lfsr;
        logic [CNT_W-1:0]  vcnt;
        logic              ser_act;
        logic              strobe;
    } st_t;

    st_t st_d, st_q;
    logic gen_run, step;
    logic [SEED_W-1:0] seed_q;

    assign seed_q  = {st_q.t, st_q.lfsr};
    assign gen_run = mode_hybrid && !par_load && !ser_load;

    tpg_pace #(.DIV_W(DIV_W)) pace_i (
        .clk(clk), .rst_n(rst_n), .run(gen_run),
        .hold_en(hold_en), .div_ratio(div_ratio), .tick(step)
    );

    tpg_synth #(.N_IN(N_IN), .T_W(T_W), .LFSR_W(LFSR_W)) synth_i (
        .t(st_q.t), .lfsr(st_q.lfsr), .row_sel(row_sel), .vec(vec_out)
    );

    always_comb begin
        st_d         = st_q;
        st_d.strobe  = 1'b0;
        st_d.ser_act = ser_load && !par_load;
        if (par_load) begin
            {st_d.t, st_d.lfsr} = par_seed;
            st_d.vcnt           = '0;
            st_d.strobe         = 1'b1;
        end else if (ser_load) begin
            {st_d.t, st_d.lfsr} = {seed_q[SEED_W-2:0], ser_bit};
            st_d.vcnt           = '0;
        end else begin
            if (st_q.ser_act) st_d.strobe = 1'b1;
            if (step) begin
                st_d.t      = st_q.t + T_W'(1);
                st_d.lfsr   = lfsr_next(st_q.lfsr);
                st_d.strobe = 1'b1;
                if (st_q.vcnt != '1) st_d.vcnt = st_q.vcnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lfsr <= RST_LFSR;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_strobe   = st_q.strobe;
    assign seed_request = mode_hybrid && (st_q.vcnt >= reseed_budget);

    // R4: parallel word lands whole in one edge and is announced
    p_par_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        par_load |=> (seed_q == $past(par_seed)) && vec_strobe);

    // R5: serial line shifts exactly one bit per edge
    p_ser_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_load && !par_load) |=> seed_q == {$past(seed_q[SEED_W-2:0]), $past(ser_bit)});

    // R6: seed-per-vector mode never moves the state by itself
    p_etm_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_hybrid && !par_load && !ser_load) |=> $stable(seed_q));

    // R7: without a load, time either holds or advances by one
    p_time_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_load && !ser_load) |=> (st_q.t == $past(st_q.t) || st_q.t == T_W'($past(st_q.t) + 1'b1)));

    // R10: a load clears the request unless the budget is zero
    p_load_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (par_load || ser_load) |=> (!seed_request || reseed_budget == '0));
endmodule

// File: tb/spectral_tpg_tb_top.sv
module spectral_tpg_tb_top;
    localparam int SEED_W = 19;
    localparam logic [23:0] ROWS_ID = 24'hFAC688;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_hybrid = 1'b0, hold_en = 1'b0;
    logic [7:0]  div_ratio = 8'd0;
    logic [15:0] reseed_budget = 16'd0;
    logic [23:0] row_sel = ROWS_ID;
    logic        par_load = 1'b0, ser_load = 1'b0, ser_bit = 1'b0;
    logic [18:0] par_seed = '0;
    logic [7:0]  vec_out;
    logic        vec_strobe, seed_request;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spectral_tpg dut_i (
        .clk(clk), .rst_n(rst_n), .mode_hybrid(mode_hybrid), .hold_en(hold_en),
        .div_ratio(div_ratio), .reseed_budget(reseed_budget), .row_sel(row_sel),
        .par_load(par_load), .par_seed(par_seed), .ser_load(ser_load), .ser_bit(ser_bit),
        .vec_out(vec_out), .vec_strobe(vec_strobe), .seed_request(seed_request)
    );

    // {seed, rows, expected vector}: seed-per-vector mode, hand-derived
    localparam logic [50:0] TBL [8] = '{
        {19'h00000, ROWS_ID,    8'hFF},
        {19'h10000, ROWS_ID,    8'h55},
        {19'h30000, ROWS_ID,    8'h99},
        {19'h70000, ROWS_ID,    8'h69},
        {19'h0FF0F, ROWS_ID,    8'hF0},
        {19'h10F33, ROWS_ID,    8'h56},
        {19'h5AA55, 24'h000000, 8'hFF},
        {19'h60101, 24'hFFFFFF, 8'hFE}
    };

    function automatic logic [7:0] mvec(input logic [2:0] t, input logic [15:0] l, input logic [23:0] rows);
        for (int i = 0; i < 8; i++)
            mvec[i] = (~^(rows[3*i +: 3] & t)) ^ (l[i] & l[i+8]);
    endfunction

    function automatic logic [18:0] mstep(input logic [18:0] s);
        logic [15:0] l = s[15:0];
        return {s[18:16] + 3'd1, l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk); #1;
    endtask

    task automatic pload(input logic [18:0] s);
        par_seed = s; par_load = 1'b1;
        edge1();
        par_load = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [18:0] m;
        edge1(); edge1();
        // R1: reset state seen through the outputs
        chk("R1 vec", vec_out, mvec(3'd0, 16'hACE1, ROWS_ID));
        chk("R1 strobe", vec_strobe, 0);
        chk("R1 request", seed_request, 0);
        rst_n = 1'b1;
        edge1();
        chk("R1 after release", vec_out, mvec(3'd0, 16'hACE1, ROWS_ID));

        // table walk: R2, R3, R4, R6
        for (int k = 0; k < 8; k++) begin
            row_sel = TBL[k][31:8];
            pload(TBL[k][50:32]);
            chk("R4 strobe", vec_strobe, 1);
            chk("R2/R3 vec", vec_out, TBL[k][7:0]);
            edge1(); edge1();
            chk("R6 frozen vec", vec_out, TBL[k][7:0]);
            chk("R6 no strobe", vec_strobe, 0);
        end
        row_sel = ROWS_ID;

        // R4: parallel load wins over serial
        par_seed = 19'h10F33; par_load = 1'b1; ser_load = 1'b1; ser_bit = 1'b1;
        edge1();
        par_load = 1'b0; ser_load = 1'b0;
        chk("R4 priority", vec_out, 8'h56);
        edge1();

        // R5 + R9: serial load in hybrid mode, no stepping while shifting
        mode_hybrid = 1'b1;
        m = 19'h3C5A9;
        for (int b = SEED_W - 1; b >= 0; b--) begin
            ser_load = 1'b1; ser_bit = m[b];
            edge1();
        end
        ser_load = 1'b0;
        chk("R5/R9 serial seed", vec_out, mvec(m[18:16], m[15:0], ROWS_ID));
        edge1();
        m = mstep(m);
        chk("R5 serial strobe", vec_strobe, 1);
        chk("R7 first step", vec_out, mvec(m[18:16], m[15:0], ROWS_ID));

        // R7/R8: free running every edge
        m = 19'h2B7E1;
        pload(m);
        chk("R7 seed shown", vec_out, mvec(m[18:16], m[15:0], ROWS_ID));
        for (int k = 1; k <= 10; k++) begin
            edge1();
            m = mstep(m);
            chk("R7 step vec", vec_out, mvec(m[18:16], m[15:0], ROWS_ID));
            chk("R8 strobe each edge", vec_strobe, 1);
        end

        // R8: hold with ratio 3
        hold_en = 1'b1; div_ratio = 8'd3;
        m = 19'h4D00D;
        pload(m);
        for (int k = 1; k <= 9; k++) begin
            edge1();
            if (k % 3 == 0) m = mstep(m);
            chk("R8 held vec", vec_out, mvec(m[18:16], m[15:0], ROWS_ID));
            chk("R8 held strobe", vec_strobe, (k % 3 == 0));
        end
        // R8: ratio 0 behaves as 1
        div_ratio = 8'd0;
        m = 19'h11234;
        pload(m);
        for (int k = 1; k <= 3; k++) begin
            edge1();
            m = mstep(m);
            chk("R8 ratio0 vec", vec_out, mvec(m[18:16], m[15:0], ROWS_ID));
        end
        hold_en = 1'b0;

        // R10: request after budget steps
        reseed_budget = 16'd4;
        pload(19'h0ABCD);
        chk("R10 cleared", seed_request, 0);
        for (int k = 1; k <= 4; k++) begin
            edge1();
            chk("R10 request", seed_request, (k >= 4));
        end
        pload(19'h0ABCD);
        chk("R10 load clears", seed_request, 0);
        mode_hybrid = 1'b0; #1;
        chk("R10 off in seed mode", seed_request, 0);
        mode_hybrid = 1'b1; reseed_budget = 16'd0; #1;
        chk("R10 zero budget", seed_request, 1);
        mode_hybrid = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule